// File: doc/BRIEF.md
# Multi-Port E1 Framer Serial Interface

This block sits between up to eight E1 framer serial links and a core that works in octets. All links share one 2.048 MHz reference clock. The block runs on a faster system clock and sees the reference clock as an input signal. Each frame has 256 bit periods, which form 32 timeslots of eight bits. Timeslot 0 comes first, and within a timeslot B1 goes first and B8 last.

On receive, the block samples each port's data line at the rising edges of the reference clock. After every B8 it hands the finished octet to the core, together with the port number and the timeslot index. One or more sync lines, sampled at the falling edges, fix where the frame starts.

On transmit, the core writes one octet per port and timeslot into a holding register. The block copies that octet to the port's output at the start of the next timeslot and shifts it out. Frame alignment is the same as on receive, and the output changes on whichever reference edge the configuration selects.

Three static configuration inputs set the behaviour:
- the sync polarity;
- whether one sync line is shared by all ports or each port has its own;
- the transmit edge.

A port produces no receive octets, and sends all ones, until it has seen its first sync.

Top module: `e1_port_iface`

## Requirements
- R1: While reset is held and right after it is released, `rxValid` is low, every `txData` bit is 1 and no port is aligned.
- R2: Until a port has seen an active sync sample, it produces no `rxValid` strobe and its `txData` bit stays 1.
- R3: Sync lines are sampled at falling edges of `refClk`. When `cfgSyncHigh` is 1, a sampled 1 is active. When it is 0, a sampled 0 is active.
- R4: With `cfgSyncPerPort` = 0, sync line 0 aligns every port and lines 1 to NUM_PORTS-1 have no effect. With `cfgSyncPerPort` = 1, line n aligns port n only.
- R5: After an active sync sample, the next rising-edge sample on that port is B1 of timeslot 0. The position then advances by one per rising edge, modulo 256. A later active sync realigns the port at once, even in the middle of a frame.
- R6: Receive bits are taken at rising edges of `refClk`. B1 becomes bit 7 of `rxOctet` and B8 becomes bit 0. Each completed octet is reported by a one-cycle `rxValid` with `rxPort` equal to the port number and `rxSlot` equal to its timeslot (0 to 31).
- R7: When several ports complete an octet in the same bit period, their strobes come out on consecutive system clock cycles in ascending port order, and none is lost. This holds as long as a half period of `refClk` is at least NUM_PORTS+4 system clocks.
- R8: A pulse on `txWrEn` stores `txWrOctet` in the holding register of port `txWrPort`. At B1 of each timeslot the port copies its holding register and transmits it with bit 7 first (B1) and bit 0 last (B8).
- R9: With `cfgTxFalling` = 0, transmit bit p changes after the rising edge at which receive bit p is sampled. With `cfgTxFalling` = 1, it changes after the falling edge just before that rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than refClk |
| rstN | input | 1 | Asynchronous active-low reset |
| refClk | input | 1 | Shared 2.048 MHz reference clock, sampled as data |
| rxData | input | NUM_PORTS | Receive serial data, one bit per port |
| syncIn | input | NUM_PORTS | Frame sync lines, one per port |
| cfgSyncHigh | input | 1 | Sync polarity: 1 = active high, 0 = active low |
| cfgSyncPerPort | input | 1 | 0 = line 0 aligns all ports, 1 = line n aligns port n |
| cfgTxFalling | input | 1 | 0 = transmit changes on the rising edge, 1 = on the falling edge |
| txWrEn | input | 1 | Write strobe for a transmit holding register |
| txWrPort | input | PORT_W | Port addressed by the write |
| txWrOctet | input | 8 | Octet to store for the next timeslot |
| txData | output | NUM_PORTS | Transmit serial data, one bit per port |
| rxValid | output | 1 | One-cycle strobe marking a received octet |
| rxPort | output | PORT_W | Port of the received octet |
| rxSlot | output | 5 | Timeslot of the received octet |
| rxOctet | output | 8 | Received octet, B1 in bit 7 |

## Verification
Under shared sync, every port reaches B8 of the same timeslot in the same bit period. That makes eight receive completions compete for the single output channel in one cycle. The bench provokes this by running a whole frame on all eight ports with one shared sync pulse. It then requires 256 strobes in strict order: within each timeslot, port 0 through port 7. Each strobe must carry the expected octet. A dropped or reordered strobe shows up as a wrong port, timeslot or count at that record.

// File: rtl/e1_iface_pkg.sv
package e1_iface_pkg;

  // Edge strobes derived from the sampled reference clock; each is high for
  // exactly one system clock cycle.
  typedef struct packed {
    logic riseTick;   // receive sampling edge
    logic fallTick;   // sync sampling edge
    logic txTick;     // edge selected for transmit updates
  } edgeStrobes_t;

endpackage

// File: rtl/e1_iface_ctrl.sv
module e1_iface_ctrl
  import e1_iface_pkg::*;
#(
  parameter int NUM_PORTS   = 8,
  parameter int SLOTS       = 32,
  parameter int SLOT_BITS   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int FRAME_BITS = SLOTS * SLOT_BITS,
  localparam int POS_W      = $clog2(FRAME_BITS),
  localparam int BIT_W      = $clog2(SLOT_BITS)
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             refClk,
  input  logic [NUM_PORTS-1:0]             syncIn,
  input  logic                             cfgSyncHigh,
  input  logic                             cfgSyncPerPort,
  input  logic                             cfgTxFalling,
  output edgeStrobes_t                     strobes,
  output logic [NUM_PORTS-1:0]             syncedVec,
  output logic [NUM_PORTS-1:0]             txActive,
  output logic [NUM_PORTS-1:0][POS_W-1:0]  rxPos,
  output logic [NUM_PORTS-1:0][BIT_W-1:0]  txBit
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

  logic [SYNC_STAGES-1:0]                refPipe;
  logic                                  refPrev;
  logic [SYNC_STAGES-1:0][NUM_PORTS-1:0] syncPipe;
  logic                                  refNow;
  logic [NUM_PORTS-1:0]                  syncNow;
  logic                                  riseTick;
  logic                                  fallTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refPipe  <= '0;
      refPrev  <= 1'b0;
      syncPipe <= '0;
    end else begin
      refPipe  <= {refPipe[SYNC_STAGES-2:0], refClk};
      refPrev  <= refPipe[SYNC_STAGES-1];
      syncPipe <= {syncPipe[SYNC_STAGES-2:0], syncIn};
    end
  end

  assign refNow   = refPipe[SYNC_STAGES-1];
  assign syncNow  = syncPipe[SYNC_STAGES-1];
  assign riseTick = refNow & ~refPrev;
  assign fallTick = ~refNow & refPrev;

  assign strobes.riseTick = riseTick;
  assign strobes.fallTick = fallTick;
  assign strobes.txTick   = cfgTxFalling ? fallTick : riseTick;

  for (genvar n = 0; n < NUM_PORTS; n++) begin : gPort
    logic             lineSel;
    logic             syncHit;
    logic [POS_W-1:0] posQ;
    logic             alignedQ;

    assign lineSel = cfgSyncPerPort ? syncNow[n] : syncNow[0];
    assign syncHit = fallTick & (lineSel == cfgSyncHigh);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        posQ     <= '0;
        alignedQ <= 1'b0;
      end else if (syncHit) begin
        posQ     <= '0;
        alignedQ <= 1'b1;
      end else if (riseTick) begin
        posQ     <= (posQ == LAST_POS) ? '0 : posQ + 1'b1;
      end
    end

    assign syncedVec[n] = alignedQ;
    assign txActive[n]  = alignedQ | syncHit;
    assign rxPos[n]     = posQ;
    assign txBit[n]     = syncHit ? '0 : posQ[BIT_W-1:0];
  end

endmodule

// File: rtl/e1_iface_dp.sv
module e1_iface_dp
  import e1_iface_pkg::*;
#(
  parameter int NUM_PORTS   = 8,
  parameter int SLOTS       = 32,
  parameter int SLOT_BITS   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int FRAME_BITS = SLOTS * SLOT_BITS,
  localparam int POS_W      = $clog2(FRAME_BITS),
  localparam int BIT_W      = $clog2(SLOT_BITS),
  localparam int SLOT_W     = $clog2(SLOTS),
  localparam int PORT_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  edgeStrobes_t                     strobes,
  input  logic [NUM_PORTS-1:0]             syncedVec,
  input  logic [NUM_PORTS-1:0]             txActive,
  input  logic [NUM_PORTS-1:0][POS_W-1:0]  rxPos,
  input  logic [NUM_PORTS-1:0][BIT_W-1:0]  txBit,
  input  logic [NUM_PORTS-1:0]             rxData,
  input  logic                             txWrEn,
  input  logic [PORT_W-1:0]                txWrPort,
  input  logic [SLOT_BITS-1:0]             txWrOctet,
  output logic [NUM_PORTS-1:0]             txData,
  output logic                             rxValid,
  output logic [PORT_W-1:0]                rxPort,
  output logic [SLOT_W-1:0]                rxSlot,
  output logic [SLOT_BITS-1:0]             rxOctet
);

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SLOT_BITS - 1);

  logic [SYNC_STAGES-1:0][NUM_PORTS-1:0]  rxPipe;
  logic [NUM_PORTS-1:0]                   rxNow;
  logic [NUM_PORTS-1:0]                   readyFlag;
  logic [NUM_PORTS-1:0][SLOT_BITS-1:0]    readyOct;
  logic [NUM_PORTS-1:0][SLOT_W-1:0]       readySlot;
  logic [NUM_PORTS-1:0]                   grant;
  logic [PORT_W-1:0]                      pickIdx;
  logic                                   pickAny;
  logic                                   unusedFall;

  assign unusedFall = strobes.fallTick;

  // Receive data follows the same synchronizer depth as the reference clock.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxPipe <= '0;
    else       rxPipe <= {rxPipe[SYNC_STAGES-2:0], rxData};
  end
  assign rxNow = rxPipe[SYNC_STAGES-1];

  for (genvar n = 0; n < NUM_PORTS; n++) begin : gLane
    logic [SLOT_BITS-1:0] rxShift;
    logic [SLOT_BITS-1:0] octDoneVal;
    logic                 octDone;
    logic                 flagQ;
    logic [SLOT_BITS-1:0] octQ;
    logic [SLOT_W-1:0]    slotQ;
    logic [SLOT_BITS-1:0] holdQ;
    logic [SLOT_BITS-1:0] txShift;
    logic                 txLine;

    assign octDoneVal = {rxShift[SLOT_BITS-2:0], rxNow[n]};
    assign octDone    = strobes.riseTick & syncedVec[n] &
                        (rxPos[n][BIT_W-1:0] == LAST_BIT);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rxShift <= '0;
        flagQ   <= 1'b0;
        octQ    <= '0;
        slotQ   <= '0;
      end else begin
        if (strobes.riseTick && syncedVec[n]) rxShift <= octDoneVal;
        if (octDone) begin
          flagQ <= 1'b1;
          octQ  <= octDoneVal;
          slotQ <= rxPos[n][POS_W-1:BIT_W];
        end else if (grant[n]) begin
          flagQ <= 1'b0;
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        holdQ   <= '1;
        txShift <= '1;
        txLine  <= 1'b1;
      end else begin
        if (txWrEn && txWrPort == PORT_W'(n)) holdQ <= txWrOctet;
        if (strobes.txTick) begin
          if (!txActive[n]) begin
            txLine <= 1'b1;
          end else if (txBit[n] == '0) begin
            txShift <= holdQ;
            txLine  <= holdQ[SLOT_BITS-1];
          end else begin
            txLine  <= txShift[LAST_BIT - txBit[n]];
          end
        end
      end
    end

    assign readyFlag[n] = flagQ;
    assign readyOct[n]  = octQ;
    assign readySlot[n] = slotQ;
    assign txData[n]    = txLine;
  end

  // Fixed priority: the lowest pending port is served first.
  always_comb begin
    grant   = '0;
    pickIdx = '0;
    pickAny = 1'b0;
    for (int n = 0; n < NUM_PORTS; n++) begin
      if (readyFlag[n] && !pickAny) begin
        pickAny  = 1'b1;
        grant[n] = 1'b1;
        pickIdx  = PORT_W'(n);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxValid <= 1'b0;
      rxPort  <= '0;
      rxSlot  <= '0;
      rxOctet <= '0;
    end else begin
      rxValid <= pickAny;
      if (pickAny) begin
        rxPort  <= pickIdx;
        rxSlot  <= readySlot[pickIdx];
        rxOctet <= readyOct[pickIdx];
      end
    end
  end

endmodule

// File: rtl/e1_port_iface.sv
module e1_port_iface
  import e1_iface_pkg::*;
#(
  parameter int NUM_PORTS   = 8,
  parameter int SLOTS       = 32,
  parameter int SLOT_BITS   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SLOT_W     = $clog2(SLOTS),
  localparam int POS_W      = $clog2(SLOTS * SLOT_BITS),
  localparam int BIT_W      = $clog2(SLOT_BITS),
  localparam int PORT_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 refClk,
  input  logic [NUM_PORTS-1:0] rxData,
  input  logic [NUM_PORTS-1:0] syncIn,
  input  logic                 cfgSyncHigh,
  input  logic                 cfgSyncPerPort,
  input  logic                 cfgTxFalling,
  input  logic                 txWrEn,
  input  logic [PORT_W-1:0]    txWrPort,
  input  logic [SLOT_BITS-1:0] txWrOctet,
  output logic [NUM_PORTS-1:0] txData,
  output logic                 rxValid,
  output logic [PORT_W-1:0]    rxPort,
  output logic [SLOT_W-1:0]    rxSlot,
  output logic [SLOT_BITS-1:0] rxOctet
);

  edgeStrobes_t                     strobes;
  logic [NUM_PORTS-1:0]             syncedVec;
  logic [NUM_PORTS-1:0]             txActive;
  logic [NUM_PORTS-1:0][POS_W-1:0]  rxPos;
  logic [NUM_PORTS-1:0][BIT_W-1:0]  txBit;

  e1_iface_ctrl #(
    .NUM_PORTS(NUM_PORTS), .SLOTS(SLOTS),
    .SLOT_BITS(SLOT_BITS), .SYNC_STAGES(SYNC_STAGES)
  ) ctrl (
    .clk(clk), .rstN(rstN), .refClk(refClk), .syncIn(syncIn),
    .cfgSyncHigh(cfgSyncHigh), .cfgSyncPerPort(cfgSyncPerPort),
    .cfgTxFalling(cfgTxFalling), .strobes(strobes), .syncedVec(syncedVec),
    .txActive(txActive), .rxPos(rxPos), .txBit(txBit)
  );

  e1_iface_dp #(
    .NUM_PORTS(NUM_PORTS), .SLOTS(SLOTS),
    .SLOT_BITS(SLOT_BITS), .SYNC_STAGES(SYNC_STAGES)
  ) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .syncedVec(syncedVec),
    .txActive(txActive), .rxPos(rxPos), .txBit(txBit), .rxData(rxData),
    .txWrEn(txWrEn), .txWrPort(txWrPort), .txWrOctet(txWrOctet),
    .txData(txData), .rxValid(rxValid), .rxPort(rxPort),
    .rxSlot(rxSlot), .rxOctet(rxOctet)
  );

endmodule

// File: rtl/e1_port_iface_chk.sv
module e1_port_iface_chk
  import e1_iface_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 rxValid,
  input logic [PORT_W-1:0]    rxPort,
  input logic [NUM_PORTS-1:0] txData,
  input logic [NUM_PORTS-1:0] syncedVec,
  input edgeStrobes_t         strobes
);

  // R2: a port not yet aligned keeps its transmit line at 1
  a_r2_idle_until_sync: assert property (@(posedge clk) disable iff (!rstN)
    &(txData | syncedVec));

  // R3: alignment state only changes right after a sync sampling edge
  a_r3_align_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(syncedVec) |-> $past(strobes.fallTick));

  // R7: back-to-back receive strobes carry rising port numbers
  a_r7_ascending_ports: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && $past(rxValid)) |-> (rxPort > $past(rxPort)));

  // R9: transmit lines move only after the selected transmit edge
  a_r9_tx_on_edge: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txData) |-> $past(strobes.txTick));

endmodule

bind e1_port_iface e1_port_iface_chk #(.NUM_PORTS(NUM_PORTS)) chkInst (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxPort(rxPort),
  .txData(txData), .syncedVec(syncedVec), .strobes(strobes)
);

// File: tb/e1_port_iface_test.sv
module e1_port_iface_test;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         refClk = 1'b0;
  logic [N-1:0] rxData = '0;
  logic [N-1:0] syncIn = '0;
  logic         cfgSyncHigh = 1'b1;
  logic         cfgSyncPerPort = 1'b0;
  logic         cfgTxFalling = 1'b0;
  logic         txWrEn = 1'b0;
  logic [2:0]   txWrPort = '0;
  logic [7:0]   txWrOctet = '0;
  logic [N-1:0] txData;
  logic         rxValid;
  logic [2:0]   rxPort;
  logic [4:0]   rxSlot;
  logic [7:0]   rxOctet;

  int nChecks = 0;
  int nErr = 0;
  int recCnt = 0;
  int recPort [0:511];
  int recSlot [0:511];
  int recOct  [0:511];

  e1_port_iface uut (
    .clk(clk), .rstN(rstN), .refClk(refClk), .rxData(rxData), .syncIn(syncIn),
    .cfgSyncHigh(cfgSyncHigh), .cfgSyncPerPort(cfgSyncPerPort),
    .cfgTxFalling(cfgTxFalling), .txWrEn(txWrEn), .txWrPort(txWrPort),
    .txWrOctet(txWrOctet), .txData(txData), .rxValid(rxValid),
    .rxPort(rxPort), .rxSlot(rxSlot), .rxOctet(rxOctet)
  );

  always #2 clk = ~clk;                    // 250 MHz
  initial begin #1; forever #64 refClk = ~refClk; end

  always @(negedge clk) begin
    if (rstN && rxValid && recCnt < 512) begin
      recPort[recCnt] = int'(rxPort);
      recSlot[recCnt] = int'(rxSlot);
      recOct[recCnt]  = int'(rxOctet);
      recCnt = recCnt + 1;
    end
  end

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rxPat(int p, int s, int seed);
    return 8'(p * 37 + s * 11 + seed * 5 + 3);
  endfunction

  function automatic logic [7:0] txPat(int p, int s, int seed);
    return 8'(p * 53 + s * 29 + seed * 7 + 1) ^ 8'h5A;
  endfunction

  task automatic applyReset(logic high, logic perPort, logic falling, logic [N-1:0] idleVec);
    cfgSyncHigh = high;
    cfgSyncPerPort = perPort;
    cfgTxFalling = falling;
    syncIn = idleVec;
    rstN = 1'b0;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    recCnt = 0;
  endtask

  task automatic writeHold(int p, logic [7:0] v);
    @(negedge clk);
    txWrEn = 1'b1;
    txWrPort = 3'(p);
    txWrOctet = v;
    @(negedge clk);
    txWrEn = 1'b0;
  endtask

  task automatic checkTx(int i, logic [N-1:0] liveMask, int seed);
    int pos = i % 256;
    for (int p = 0; p < N; p++) begin
      logic [7:0] oct = txPat(p, pos / 8, seed);
      int exp = liveMask[p] ? int'(oct[7 - pos % 8]) : 1;
      check(cfgTxFalling ? "R9 falling tx / R8" : "R9 rising tx / R8", int'(txData[p]), exp);
    end
  endtask

  task automatic runFrame(int nBits, logic [N-1:0] pulseVec, logic [N-1:0] idleVec,
                          logic [N-1:0] liveMask, int seed);
    for (int p = 0; p < N; p++) if (liveMask[p]) writeHold(p, txPat(p, 0, seed));
    @(posedge refClk);
    syncIn = pulseVec;
    for (int i = 0; i < nBits; i++) begin
      int pos = i % 256;
      int s = pos / 8;
      int b = pos % 8;
      @(negedge refClk);
      if (!cfgTxFalling && i > 0) checkTx(i - 1, liveMask, seed);
      for (int p = 0; p < N; p++) begin
        logic [7:0] oct = rxPat(p, s, seed);
        rxData[p] = oct[7 - b];
      end
      if (b == 1)
        for (int p = 0; p < N; p++)
          if (liveMask[p]) writeHold(p, txPat(p, (s + 1) % 32, seed));
      @(posedge refClk);
      if (i == 0) syncIn = idleVec;
      if (cfgTxFalling) checkTx(i, liveMask, seed);
    end
    @(negedge refClk);
    if (!cfgTxFalling) checkTx(nBits - 1, liveMask, seed);
    repeat (30) @(posedge clk);
  endtask

  task automatic checkRec(int k, int p, int s, int seed);
    check("R7 port order", recPort[k], p);
    check("R5 timeslot index", recSlot[k], s);
    check("R6 octet value", recOct[k], int'(rxPat(p, s, seed)));
  endtask

  // R1: outputs right after reset
  task automatic testReset();
    applyReset(1'b1, 1'b0, 1'b0, '0);
    @(negedge clk);
    check("R1 rxValid after reset", int'(rxValid), 0);
    check("R1 txData after reset", int'(txData), 'hFF);
  endtask

  // R2: data but no sync -> silence on both directions
  task automatic testNoSync();
    applyReset(1'b1, 1'b0, 1'b0, '0);
    runFrame(24, '0, '0, '0, 4);
    check("R2 no strobes before sync", recCnt, 0);
  endtask

  // R4/R3/R6/R7: shared sync on line 0, lines 1..7 held at the active level
  task automatic testSharedFrame();
    applyReset(1'b1, 1'b0, 1'b0, 8'hFE);
    runFrame(256, 8'hFF, 8'hFE, 8'hFF, 1);
    check("R4 shared sync strobe count", recCnt, 256);
    for (int k = 0; k < 256 && k < recCnt; k++) checkRec(k, k % 8, k / 8, 1);
  endtask

  // R3/R4/R5: active-low per-port sync on port 3 only, falling tx, realign mid-frame
  task automatic testPerPortRealign();
    applyReset(1'b0, 1'b1, 1'b1, 8'hFF);
    runFrame(20, 8'hF7, 8'hFF, 8'h08, 2);
    check("R3 active-low per-port count", recCnt, 2);
    if (recCnt >= 2) begin
      checkRec(0, 3, 0, 2);
      checkRec(1, 3, 1, 2);
    end
    runFrame(16, 8'hF7, 8'hFF, 8'h08, 3);
    check("R5 realign count", recCnt, 4);
    if (recCnt >= 4) begin
      checkRec(2, 3, 0, 3);
      checkRec(3, 3, 1, 3);
    end
  endtask

  initial begin
    #(4 * 150000);
    nErr++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    testReset();
    testNoSync();
    testSharedFrame();
    testPerPortRealign();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule